// File: doc/BRIEF.md
# Raster LCD Timing Generator

This block produces the scan timing for a raster LCD panel. It outputs horizontal and vertical sync, a display-enable strobe and the current pixel and line positions, one pixel per clock. Software programs it through a write-only port that carries an address, 16 bits of data and a strobe. The horizontal quantities are given in character units of `2**CHAR_SHIFT` pixels (8 by default). The vertical quantities are given in lines. Every count field holds its value minus one.

The timing fields are held in a live copy and a shadow copy. The scan always runs from the shadow copy, and that copy is refreshed only when a frame ends. A reprogrammed mode therefore never tears a frame.

A 2-bit control field sets the state of the panel. The display counts as fully on only when both control bits are set. While it is not fully on, the display-enable output is held low and both syncs are held at their inactive level. A 2-bit power status moves one step every `PWR_FRAMES` frames toward its target: 3 when the display is fully on, 0 otherwise. Software polls this status to learn when the panel supply has settled. A sticky interrupt marks the start of vertical sync while its enable bit is set, and it drops as soon as that bit is cleared.

Top module: `lcd_tgen`

## Requirements
- R1: While reset is held, all of these outputs read zero: `h_pos_o`, `v_pos_o`, `de_o`, `hsync_o`, `vsync_o`, `irq_o` and `pwr_state_o`.
- R2: `h_pos_o` counts from 0 to T·2^CHAR_SHIFT−1 and then wraps to 0, where address 0 bits [7:0] hold T−1 (T is the total width in characters). At each wrap, `v_pos_o` advances by one. `v_pos_o` wraps to 0 after line L−1, where address 3 bits [11:0] hold L−1 (L is the total number of lines).
- R3: `de_o` is high only when three conditions hold: the display is fully on, `h_pos_o` is below A·2^CHAR_SHIFT, and `v_pos_o` is below D. Address 0 bits [15:8] hold A−1 (A is the active width in characters). Address 2 bits [11:0] hold D−1 (D is the number of active lines).
- R4: The raw horizontal sync is active while `h_pos_o` lies in [P·2^CHAR_SHIFT, (P+W)·2^CHAR_SHIFT). Address 1 bits [7:0] hold P−1 and bits [15:12] hold W−1.
- R5: The raw vertical sync is active while `v_pos_o` lies in [S, S+N). Address 4 bits [11:0] hold S−1 and bits [15:12] hold N−1.
- R6: Address 5 bit 0 inverts `hsync_o` and address 5 bit 1 inverts `vsync_o`. A set bit means that sync is active low.
- R7: Address 6 bits [1:0] form the control field, and 2'b11 means fully on. When the field holds any other value, `de_o` is low and each sync stays at its inactive level.
- R8: A write to addresses 0 through 5 takes effect at the first pixel of the next frame. The frame in progress keeps its old timing.
- R9: `pwr_state_o` moves one step every `PWR_FRAMES` completed frames toward its target, and never skips a value. The target is 3 when the display is fully on and 0 otherwise.
- R10: Address 7 bit 0 is the interrupt enable. While it is set, `irq_o` rises one cycle after the first pixel of the first vertical-sync line and then holds. When the enable is cleared, `irq_o` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| h_pos_o | output | 12 | Pixel index within the line |
| v_pos_o | output | 12 | Line index within the frame |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| irq_o | output | 1 | Sticky vertical-sync interrupt |
| pwr_state_o | output | 2 | Power-state status |

## Verification
The hardest case to reach is a timing write that lands in the middle of a frame. In that case the line must still wrap at the old width, and the new width must apply only after the frame boundary.

The bench waits for a chosen position, then rewrites the total width, the sync and the vertical geometry. It then checks that the line in progress wraps at the old last pixel. A cycle-accurate reference model feeds the scoreboard, so every later cycle is also compared against the new mode. The power ramp is covered in both directions by holding each control setting for enough frames to pass all intermediate states.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int HCHAR_W = 8;
    localparam int SW_W    = 4;
    localparam int VLINE_W = 12;

    typedef enum logic [ADDR_W-1:0] {
        A_HTIM = 3'd0,
        A_HSYN = 3'd1,
        A_VACT = 3'd2,
        A_VTOT = 3'd3,
        A_VSYN = 3'd4,
        A_POL  = 3'd5,
        A_CTRL = 3'd6,
        A_IRQ  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        PWR_OFF = 2'd0,
        PWR_LO  = 2'd1,
        PWR_HI  = 2'd2,
        PWR_ON  = 2'd3
    } pwr_e;

    typedef struct packed {
        logic [HCHAR_W-1:0] htot;
        logic [HCHAR_W-1:0] hact;
        logic [HCHAR_W-1:0] hsp;
        logic [SW_W-1:0]    hsw;
        logic [VLINE_W-1:0] vact;
        logic [VLINE_W-1:0] vtot;
        logic [VLINE_W-1:0] vsp;
        logic [SW_W-1:0]    vsw;
        logic               hpol;
        logic               vpol;
    } tcfg_t;

    // 32 px per line (16 active), 10 lines per frame (6 active)
    localparam tcfg_t CFG_RST = '{
        htot: 8'd3,  hact: 8'd1,  hsp: 8'd2,  hsw: 4'd0,
        vact: 12'd5, vtot: 12'd9, vsp: 12'd6, vsw: 4'd1,
        hpol: 1'b0,  vpol: 1'b0
    };

    function automatic int unsigned chars_to_px(input logic [HCHAR_W-1:0] f,
                                                input int unsigned sh);
        return (32'(f) + 32'd1) << sh;
    endfunction

    function automatic int unsigned m1_to_n(input logic [VLINE_W-1:0] f);
        return 32'(f) + 32'd1;
    endfunction

    function automatic logic in_window(input int unsigned pos,
                                       input int unsigned start,
                                       input int unsigned len);
        return (pos >= start) && (pos < start + len);
    endfunction

endpackage

// File: rtl/lcd_tgen_regs.sv
module lcd_tgen_regs
    import lcd_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              frame_end_i,
    output tcfg_t             act_o,
    output logic [1:0]        ctrl_o,
    output logic              irq_en_o
);

    tcfg_t live_q;
    tcfg_t act_q;
    logic [1:0] ctrl_q;
    logic irq_en_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= CFG_RST;
            ctrl_q   <= 2'b00;
            irq_en_q <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_HTIM: begin
                    live_q.htot <= wr_data[7:0];
                    live_q.hact <= wr_data[15:8];
                end
                A_HSYN: begin
                    live_q.hsp <= wr_data[7:0];
                    live_q.hsw <= wr_data[15:12];
                end
                A_VACT: live_q.vact <= wr_data[11:0];
                A_VTOT: live_q.vtot <= wr_data[11:0];
                A_VSYN: begin
                    live_q.vsp <= wr_data[11:0];
                    live_q.vsw <= wr_data[15:12];
                end
                A_POL: begin
                    live_q.hpol <= wr_data[0];
                    live_q.vpol <= wr_data[1];
                end
                A_CTRL: ctrl_q   <= wr_data[1:0];
                A_IRQ:  irq_en_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    // shadow copy: refreshed only on the last pixel of a frame
    always_ff @(posedge clk) begin
        if (rst)              act_q <= CFG_RST;
        else if (frame_end_i) act_q <= live_q;
    end

    assign act_o    = act_q;
    assign ctrl_o   = ctrl_q;
    assign irq_en_o = irq_en_q;

endmodule

// File: rtl/lcd_tgen_scan.sv
module lcd_tgen_scan
    import lcd_tgen_pkg::*;
#(
    parameter int CHAR_SHIFT = 3,
    parameter int PX_W       = HCHAR_W + 1 + CHAR_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  tcfg_t              cfg_i,
    input  logic               full_on_i,
    input  logic               irq_en_i,
    output logic [PX_W-1:0]    h_pos_o,
    output logic [VLINE_W-1:0] v_pos_o,
    output logic               de_o,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               irq_o,
    output logic               frame_end_o
);

    logic [PX_W-1:0]    h_q;
    logic [VLINE_W-1:0] v_q;
    logic               irq_q;
    int unsigned h_total, h_act, h_sp, h_sw;
    int unsigned v_total, v_act, v_sp, v_sw;
    int unsigned h_now, v_now;
    logic line_end, frame_end, vs_start, hs_raw, vs_raw;

    always_comb begin
        h_total   = chars_to_px(cfg_i.htot, CHAR_SHIFT);
        h_act     = chars_to_px(cfg_i.hact, CHAR_SHIFT);
        h_sp      = chars_to_px(cfg_i.hsp, CHAR_SHIFT);
        h_sw      = chars_to_px(HCHAR_W'(cfg_i.hsw), CHAR_SHIFT);
        v_total   = m1_to_n(cfg_i.vtot);
        v_act     = m1_to_n(cfg_i.vact);
        v_sp      = m1_to_n(cfg_i.vsp);
        v_sw      = m1_to_n(VLINE_W'(cfg_i.vsw));
        h_now     = 32'(h_q);
        v_now     = 32'(v_q);
        line_end  = (h_now == h_total - 32'd1);
        frame_end = line_end && (v_now == v_total - 32'd1);
        vs_start  = (h_now == 32'd0) && (v_now == v_sp);
        hs_raw    = in_window(h_now, h_sp, h_sw);
        vs_raw    = in_window(v_now, v_sp, v_sw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q   <= '0;
            v_q   <= '0;
            irq_q <= 1'b0;
        end else begin
            if (line_end) begin
                h_q <= '0;
                v_q <= frame_end ? '0 : v_q + 1'b1;
            end else begin
                h_q <= h_q + 1'b1;
            end
            irq_q <= irq_en_i ? (irq_q | vs_start) : 1'b0;
        end
    end

    assign h_pos_o     = h_q;
    assign v_pos_o     = v_q;
    assign de_o        = full_on_i && (h_now < h_act) && (v_now < v_act);
    assign hsync_o     = (full_on_i && hs_raw) ^ cfg_i.hpol;
    assign vsync_o     = (full_on_i && vs_raw) ^ cfg_i.vpol;
    assign irq_o       = irq_q;
    assign frame_end_o = frame_end;

endmodule

// File: rtl/lcd_tgen_pwr.sv
module lcd_tgen_pwr
    import lcd_tgen_pkg::*;
#(
    parameter int PWR_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic full_on_i,
    input  logic frame_end_i,
    output pwr_e state_o
);

    localparam int CW = (PWR_FRAMES > 1) ? $clog2(PWR_FRAMES) : 1;

    pwr_e         st_q;
    pwr_e         target;
    logic [CW-1:0] cnt_q;

    assign target = full_on_i ? PWR_ON : PWR_OFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
        end else if (st_q == target) begin
            cnt_q <= '0;
        end else if (frame_end_i) begin
            if (cnt_q == CW'(PWR_FRAMES - 1)) begin
                cnt_q <= '0;
                st_q  <= (st_q < target) ? pwr_e'(st_q + 2'd1)
                                         : pwr_e'(st_q - 2'd1);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter int CHAR_SHIFT = 3,
    parameter int PWR_FRAMES = 2,
    localparam int PX_W      = HCHAR_W + 1 + CHAR_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [PX_W-1:0]    h_pos_o,
    output logic [VLINE_W-1:0] v_pos_o,
    output logic               de_o,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               irq_o,
    output logic [1:0]         pwr_state_o
);

    tcfg_t      act_cfg;
    logic [1:0] ctrl_q;
    logic       irq_en_q;
    logic       frame_end;
    logic       full_on;
    pwr_e       pwr_st;

    assign full_on = (ctrl_q == 2'b11);

    lcd_tgen_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_end_i (frame_end),
        .act_o       (act_cfg),
        .ctrl_o      (ctrl_q),
        .irq_en_o    (irq_en_q)
    );

    lcd_tgen_scan #(
        .CHAR_SHIFT (CHAR_SHIFT),
        .PX_W       (PX_W)
    ) u_scan (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (act_cfg),
        .full_on_i   (full_on),
        .irq_en_i    (irq_en_q),
        .h_pos_o     (h_pos_o),
        .v_pos_o     (v_pos_o),
        .de_o        (de_o),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .irq_o       (irq_o),
        .frame_end_o (frame_end)
    );

    lcd_tgen_pwr #(
        .PWR_FRAMES (PWR_FRAMES)
    ) u_pwr (
        .clk         (clk),
        .rst         (rst),
        .full_on_i   (full_on),
        .frame_end_i (frame_end),
        .state_o     (pwr_st)
    );

    assign pwr_state_o = pwr_st;

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
    parameter int PX_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [PX_W-1:0] h_pos,
    input logic [11:0]     v_pos,
    input logic [11:0]     vtot,
    input logic [11:0]     vact,
    input logic [11:0]     vsp,
    input logic            de,
    input logic            irq,
    input logic            irq_en,
    input logic [1:0]      ctrl,
    input logic [1:0]      pwr
);

    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (rst)
        (h_pos != '0) |-> (h_pos == $past(h_pos) + 1'b1));                // R2

    AST_VPOS_RANGE: assert property (@(posedge clk) disable iff (rst)
        v_pos <= vtot);                                                   // R2

    AST_DE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        de |-> (v_pos <= vact));                                          // R3

    AST_DE_OFF: assert property (@(posedge clk) disable iff (rst)
        (ctrl != 2'b11) |-> !de);                                         // R7

    AST_PWR_STEP: assert property (@(posedge clk) disable iff (rst)
        (pwr != $past(pwr)) |->
        ((pwr > $past(pwr)) ? (pwr - $past(pwr) == 2'd1)
                            : ($past(pwr) - pwr == 2'd1)));               // R9

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !irq);                                                // R10

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (irq_en && h_pos == '0 && {1'b0, v_pos} == {1'b0, vsp} + 13'd1)
        |=> (irq || !irq_en));                                            // R10

endmodule

bind lcd_tgen lcd_tgen_chk #(.PX_W(PX_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .h_pos  (h_pos_o),
    .v_pos  (v_pos_o),
    .vtot   (act_cfg.vtot),
    .vact   (act_cfg.vact),
    .vsp    (act_cfg.vsp),
    .de     (de_o),
    .irq    (irq_o),
    .irq_en (irq_en_q),
    .ctrl   (ctrl_q),
    .pwr    (pwr_state_o)
);

// File: tb/sim_lcd_tgen.sv
module sim_lcd_tgen;
    import lcd_tgen_pkg::*;

    localparam int S    = 3;
    localparam int PF   = 2;
    localparam int PX_W = HCHAR_W + 1 + S;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [REG_W-1:0]   wr_data;
    logic [PX_W-1:0]    h_pos_o;
    logic [VLINE_W-1:0] v_pos_o;
    logic de_o, hsync_o, vsync_o, irq_o;
    logic [1:0] pwr_state_o;

    lcd_tgen #(.CHAR_SHIFT(S), .PWR_FRAMES(PF)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_pos_o(h_pos_o), .v_pos_o(v_pos_o), .de_o(de_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .irq_o(irq_o), .pwr_state_o(pwr_state_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    tcfg_t m_live, m_act;
    logic [1:0] m_ctrl;
    logic m_ien, m_irq;
    int m_h, m_v, m_pwr, m_pcnt;

    always @(posedge clk) begin : model
        int ht, vt, vsl, tgt;
        logic fend, vsst;
        ht   = (int'(m_act.htot) + 1) << S;
        vt   = int'(m_act.vtot) + 1;
        vsl  = int'(m_act.vsp) + 1;
        fend = (m_h == ht - 1) && (m_v == vt - 1);
        vsst = (m_h == 0) && (m_v == vsl);
        tgt  = (m_ctrl == 2'b11) ? 3 : 0;
        if (rst) begin
            m_live <= CFG_RST; m_act <= CFG_RST; m_ctrl <= 2'b00; m_ien <= 1'b0;
            m_irq <= 1'b0; m_h <= 0; m_v <= 0; m_pwr <= 0; m_pcnt <= 0;
        end else begin
            if (m_h == ht - 1) begin
                m_h <= 0;
                m_v <= fend ? 0 : m_v + 1;
            end else m_h <= m_h + 1;
            if (fend) m_act <= m_live;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_live.htot <= wr_data[7:0]; m_live.hact <= wr_data[15:8]; end
                    3'd1: begin m_live.hsp <= wr_data[7:0]; m_live.hsw <= wr_data[15:12]; end
                    3'd2: m_live.vact <= wr_data[11:0];
                    3'd3: m_live.vtot <= wr_data[11:0];
                    3'd4: begin m_live.vsp <= wr_data[11:0]; m_live.vsw <= wr_data[15:12]; end
                    3'd5: begin m_live.hpol <= wr_data[0]; m_live.vpol <= wr_data[1]; end
                    3'd6: m_ctrl <= wr_data[1:0];
                    default: m_ien <= wr_data[0];
                endcase
            end
            m_irq <= m_ien ? (m_irq | vsst) : 1'b0;
            if (m_pwr == tgt) m_pcnt <= 0;
            else if (fend) begin
                if (m_pcnt == PF - 1) begin
                    m_pcnt <= 0;
                    m_pwr  <= (m_pwr < tgt) ? m_pwr + 1 : m_pwr - 1;
                end else m_pcnt <= m_pcnt + 1;
            end
        end
    end

    typedef struct {
        int h, v, pwr;
        logic de, hs, vs, irq;
    } exp_t;
    exp_t q[$];

    function automatic exp_t expect_now();
        exp_t e;
        logic on;
        int hsp, hsw, vsp, vsw;
        on  = (m_ctrl == 2'b11);
        hsp = (int'(m_act.hsp) + 1) << S;
        hsw = (int'(m_act.hsw) + 1) << S;
        vsp = int'(m_act.vsp) + 1;
        vsw = int'(m_act.vsw) + 1;
        e.h   = m_h;
        e.v   = m_v;
        e.pwr = m_pwr;
        e.irq = m_irq;
        e.de  = on && (m_h < ((int'(m_act.hact) + 1) << S)) && (m_v < int'(m_act.vact) + 1);
        e.hs  = (on && m_h >= hsp && m_h < hsp + hsw) ^ m_act.hpol;
        e.vs  = (on && m_v >= vsp && m_v < vsp + vsw) ^ m_act.vpol;
        return e;
    endfunction

    // driver side of the scoreboard: one expected item per clock
    always @(posedge clk) begin
        #1;
        if (!rst) q.push_back(expect_now());
    end

    // monitor side: compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(int'(h_pos_o) == e.h, "R2 R8", "h_pos", int'(h_pos_o), e.h);
            check(int'(v_pos_o) == e.v, "R2 R8", "v_pos", int'(v_pos_o), e.v);
            check(de_o == e.de, "R3 R7", "de", int'(de_o), int'(e.de));
            check(hsync_o == e.hs, "R4 R6", "hsync", int'(hsync_o), int'(e.hs));
            check(vsync_o == e.vs, "R5 R6", "vsync", int'(vsync_o), int'(e.vs));
            check(int'(pwr_state_o) == e.pwr, "R9", "pwr", int'(pwr_state_o), e.pwr);
            check(irq_o == e.irq, "R10", "irq", int'(irq_o), int'(e.irq));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pos(input int h, input int v);
        while (!(int'(h_pos_o) == h && int'(v_pos_o) == v)) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt, hs_lo;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(h_pos_o == '0 && v_pos_o == '0, "R1", "pos", int'(h_pos_o), 0);
        check(!de_o && !hsync_o && !vsync_o, "R1", "de/syncs", int'({de_o, hsync_o, vsync_o}), 0);
        check(!irq_o && pwr_state_o == 2'd0, "R1", "irq/pwr", int'({irq_o, pwr_state_o}), 0);
        rst = 1'b0;

        repeat (400) @(negedge clk);          // one frame with display off
        wr(3'd7, 16'h0001);                   // interrupt enable
        wr(3'd6, 16'h0003);                   // fully on
        repeat (8 * 320) @(negedge clk);
        check(pwr_state_o == 2'd3, "R9", "ramp up", int'(pwr_state_o), 3);
        check(irq_o == 1'b1, "R10", "irq sticky", int'(irq_o), 1);

        // R3 active pixel count over one default frame: 16 px * 6 lines
        wait_pos(0, 0);
        cnt = 0;
        for (int i = 0; i < 320; i++) begin
            if (de_o) cnt++;
            @(negedge clk);
        end
        check(cnt == 96, "R3", "de count", cnt, 96);

        wr(3'd5, 16'h0003);                   // both syncs active low
        // R8: mid-frame reconfiguration, old line width must still apply
        wait_pos(5, 2);
        wr(3'd0, 16'h0204);                   // 5 chars total, 3 active
        wr(3'd1, 16'h0003);                   // sync at char 4, 1 char wide
        wr(3'd2, 16'h0007);
        wr(3'd3, 16'h000b);
        wr(3'd4, 16'h1008);
        while (int'(h_pos_o) != 31) @(negedge clk);
        @(negedge clk);
        check(h_pos_o == '0, "R8", "old wrap kept", int'(h_pos_o), 0);
        wait_pos(0, 0);
        while (int'(h_pos_o) != 39) @(negedge clk);
        @(negedge clk);
        check(h_pos_o == '0, "R8", "new wrap applied", int'(h_pos_o), 0);

        repeat (3 * 480) @(negedge clk);
        wr(3'd7, 16'h0000);
        @(negedge clk);
        check(irq_o == 1'b0, "R10", "irq cleared", int'(irq_o), 0);

        wr(3'd6, 16'h0001);                   // logic only, not fully on
        wait_pos(0, 0);
        cnt = 0; hs_lo = 0;
        for (int i = 0; i < 480; i++) begin
            if (de_o) cnt++;
            if (!hsync_o || !vsync_o) hs_lo++;
            @(negedge clk);
        end
        check(cnt == 0, "R7", "de while off", cnt, 0);
        check(hs_lo == 0, "R7", "syncs inactive", hs_lo, 0);
        repeat (8 * 480) @(negedge clk);
        check(pwr_state_o == 2'd0, "R9", "ramp down", int'(pwr_state_o), 0);

        finish_run();
    end

endmodule